// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Thresholds

The block buffers 512 words of 9 bits between a writer on one clock and a reader on another. Each side controls its port with active-low enables. The writer uses one enable plus a shared load-select pin. The reader uses two enables that must both be low. Four status outputs are provided: empty, full, almost-empty and almost-full. Empty and almost-empty are generated in the read clock domain. Full and almost-full are generated in the write clock domain. Each side compares its own binary pointer with a Gray-coded, synchronised copy of the other side's pointer.

Two offset registers set the almost thresholds. Both hold 7 after reset. When the load-select pin is driven low, the data buses reach these registers instead of the storage. Enabled writes load the empty offset and then the full offset, and the sequence then wraps. Enabled reads return the two offsets on the read data bus in the same alternating order.

Back-pressure rules: a write enable counts as a valid offer, and `full` low is the ready. An offer made while `full` is high is dropped, and the writer must present it again. On the read side, `empty` low means data is available. A read attempted while `empty` is high does nothing, and `rd_data` keeps its previous value. The load-select pin is treated as quasi-static across both clocks.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `rd_data`=0. Both offset registers hold 7.
- R2: A word is stored on a rising `wclk` edge only when `wr_en_n`=0, `wr_ld_n`=1 and `full`=0. A write attempted while full is dropped and never read out.
- R3: When `rd_en_a_n`=0, `rd_en_b_n`=0, `wr_ld_n`=1 and `empty`=0, the oldest word appears on `rd_data` after that `rclk` edge. When `empty`=1, such a read leaves `rd_data` unchanged.
- R4: Words leave in the order they were written. `full` rises when the 512th unread word is stored.
- R5: `almost_empty` is 1 exactly when the number of stored words seen by the read side is less than or equal to the empty offset.
- R6: `almost_full` is 1 exactly when the number of free locations seen by the write side is less than or equal to the full offset.
- R7: With `wr_ld_n`=0, each `wclk` edge with `wr_en_n`=0 loads `wr_data[8:0]` into an offset register. The empty offset is loaded first, then the full offset, and the sequence wraps. The storage and the pointers are not touched.
- R8: With `wr_ld_n`=0, each `rclk` edge with both read enables low puts an offset on `rd_data`. The empty offset comes first, then the full offset, and the sequence wraps. The read pointer does not move.
- R9: A write into an empty FIFO clears `empty` after the second `rclk` edge following the write edge; it is still 1 after the first edge. A read updates `empty` after the same edge, with no added delay.
- R10: Simultaneous reads and writes on a partly filled FIFO leave the word count, and therefore the flags, unchanged. `full` and `empty` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_data | input | 9 | Write data, or an offset value when loading |
| wr_en_n | input | 1 | Active-low write enable |
| wr_ld_n | input | 1 | High selects the FIFO; low selects offset-register access |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| rd_data | output | 9 | Registered read data, or an offset readback |
| empty | output | 1 | No words available (read domain) |
| almost_empty | output | 1 | Word count at or below the empty offset (read domain) |
| almost_full | output | 1 | Free space at or below the full offset (write domain) |
| full | output | 1 | No free location (write domain) |

## Verification
Read data and offset readback are due one edge after the enabling edge, so the bench drives on falling edges and compares on the next falling edge. Full and almost-full change on the same write edge that causes them, and the bench checks them right after the edge. Empty and almost-empty react to writes only after the two-stage synchroniser. The bench therefore checks `empty` just before and just after the second read edge, and waits three idle cycles before it samples almost-empty. A scoreboard queue holds every word the bench expects to be accepted, and the monitor pops from it one cycle after each read that the bench expects to succeed.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} pf_sel_e;

  function automatic pf_sel_e pf_next_sel(input pf_sel_e s);
    return (s == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction
endpackage

// File: rtl/pf_sync.sv
`timescale 1ns/1ps
module pf_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pf_offsets.sv
`timescale 1ns/1ps
module pf_offsets import pf_pkg::*; #(
  parameter int AW      = 9,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ld_wr,
  input  logic [AW-1:0] ld_data,
  input  logic          ld_rd,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic [AW-1:0] rb_data
);
  pf_sel_e wsel, rsel;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= AW'(DEF_OFF);
      af_off <= AW'(DEF_OFF);
      wsel   <= SEL_AE;
    end else if (ld_wr) begin
      if (wsel == SEL_AE) ae_off <= ld_data;
      else                af_off <= ld_data;
      wsel <= pf_next_sel(wsel);
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)     rsel <= SEL_AE;
    else if (ld_rd) rsel <= pf_next_sel(rsel);
  end

  assign rb_data = (rsel == SEL_AE) ? ae_off : af_off;

  a_r7_first_load_ae: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_wr && wsel == SEL_AE) |=> (ae_off == $past(ld_data) && $stable(af_off)));
  a_r7_second_load_af: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_wr && wsel == SEL_AF) |=> (af_off == $past(ld_data) && $stable(ae_off)));
endmodule

// File: rtl/pf_wr_ctrl.sv
`timescale 1ns/1ps
module pf_wr_ctrl #(
  parameter int AW   = 9,
  parameter int SYNC = 2
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_x,
  input  logic [AW-1:0] af_off,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_fire,
  output logic          full,
  output logic          almost_full
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] DEPTH = PW'(1) << AW;

  logic [AW:0] wbin, wnext, rgray_s, rbin_s, used, free;

  pf_sync #(.W(PW), .STAGES(SYNC)) u_sync (
    .clk(wclk), .rst_n(rst_n), .d(rgray_x), .q(rgray_s)
  );

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign used        = wbin - rbin_s;
  assign full        = used[AW];
  assign free        = DEPTH - used;
  assign almost_full = free <= {1'b0, af_off};
  assign wr_fire     = wr_req & ~full;
  assign wnext       = wbin + PW'(1);
  assign waddr       = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end

  a_r2_full_blocks_write: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_req) |=> $stable(wbin));
  a_r4_count_bound: assert property (@(posedge wclk) disable iff (!rst_n)
    used <= DEPTH);
  a_r6_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
endmodule

// File: rtl/pf_rd_ctrl.sv
`timescale 1ns/1ps
module pf_rd_ctrl #(
  parameter int AW   = 9,
  parameter int SYNC = 2
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW:0]   wgray_x,
  input  logic [AW-1:0] ae_off,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rd_fire,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic [AW:0] rbin, rnext, wgray_s, wbin_s, used;

  pf_sync #(.W(PW), .STAGES(SYNC)) u_sync (
    .clk(rclk), .rst_n(rst_n), .d(wgray_x), .q(wgray_s)
  );

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign used         = wbin_s - rbin;
  assign empty        = (used == '0);
  assign almost_empty = used <= {1'b0, ae_off};
  assign rd_fire      = rd_req & ~empty;
  assign rnext        = rbin + PW'(1);
  assign raddr        = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rnext;
      rgray <= rnext ^ (rnext >> 1);
    end
  end

  a_r3_empty_blocks_read: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_req) |=> $stable(rbin));
  a_r5_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
  parameter int DW      = 9,
  parameter int AW      = 9,
  parameter int SYNC    = 2,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_n,
  input  logic          wr_ld_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          full
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] waddr, raddr, ae_off, af_off, rb_data;
  logic [AW:0]   wgray, rgray;
  logic          wr_req, ld_wr, rd_any, rd_req, ld_rd, wr_fire, rd_fire;

  assign wr_req = ~wr_en_n & wr_ld_n;
  assign ld_wr  = ~wr_en_n & ~wr_ld_n;
  assign rd_any = ~rd_en_a_n & ~rd_en_b_n;
  assign rd_req = rd_any & wr_ld_n;
  assign ld_rd  = rd_any & ~wr_ld_n;

  pf_offsets #(.AW(AW), .DEF_OFF(DEF_OFF)) u_offs (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .ld_wr(ld_wr), .ld_data(wr_data[AW-1:0]), .ld_rd(ld_rd),
    .ae_off(ae_off), .af_off(af_off), .rb_data(rb_data)
  );

  pf_wr_ctrl #(.AW(AW), .SYNC(SYNC)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rgray_x(rgray),
    .af_off(af_off), .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire),
    .full(full), .almost_full(almost_full)
  );

  pf_rd_ctrl #(.AW(AW), .SYNC(SYNC)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wgray_x(wgray),
    .ae_off(ae_off), .raddr(raddr), .rgray(rgray), .rd_fire(rd_fire),
    .empty(empty), .almost_empty(almost_empty)
  );

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (ld_rd)   rd_data <= DW'(rb_data);
    else if (rd_fire) rd_data <= mem[raddr];
  end

  a_r3_rd_data_holds: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_fire && !ld_rd) |=> $stable(rd_data));
  a_r10_not_full_and_empty: assert property (@(posedge wclk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/sim_prog_flag_fifo.sv
`timescale 1ns/1ps
module sim_prog_flag_fifo;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [8:0] wr_data;
  logic       wr_en_n, wr_ld_n, rd_en_a_n, rd_en_b_n;
  logic [8:0] rd_data;
  logic       empty, almost_empty, almost_full, full;

  int n_cmp = 0;
  int n_bad = 0;
  int mcount = 0;
  int exp_q[$];
  logic mon_arm = 1'b0;
  logic mon_cap = 1'b0;

  prog_flag_fifo u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en_n(wr_en_n), .wr_ld_n(wr_ld_n), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .rd_data(rd_data), .empty(empty),
    .almost_empty(almost_empty), .almost_full(almost_full), .full(full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic ld, input logic ra,
                     input logic rb, input logic [8:0] d);
    wr_en_n = we; wr_ld_n = ld; rd_en_a_n = ra; rd_en_b_n = rb; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    mon_arm = 1'b0;
    repeat (n) cyc(1, 1, 1, 1, 9'd0);
  endtask

  task automatic push(input logic [8:0] d);
    mon_arm = 1'b0;
    if (mcount < 512) begin exp_q.push_back(int'(d)); mcount++; end
    cyc(0, 1, 1, 1, d);
  endtask

  task automatic pop();
    mon_arm = (mcount > 0);
    if (mcount > 0) mcount--;
    cyc(1, 1, 0, 0, 9'd0);
  endtask

  task automatic both(input logic [8:0] d);
    mon_arm = (mcount > 0);
    exp_q.push_back(int'(d));
    cyc(0, 1, 0, 0, d);
  endtask

  task automatic load(input logic [8:0] d);
    mon_arm = 1'b0;
    cyc(0, 0, 1, 1, d);
  endtask

  task automatic readback(input int exp, input string req);
    mon_arm = 1'b0;
    cyc(1, 0, 0, 0, 9'd0);
    chk(req, int'(rd_data), exp);
  endtask

  // scoreboard monitor: read data is due one edge after an accepted read
  always @(posedge clk) mon_cap <= mon_arm;
  always @(negedge clk) begin
    if (mon_cap) begin
      if (exp_q.size() == 0) chk("R4 unexpected read", 1, 0);
      else chk("R3/R4 read data order", int'(rd_data), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] last;
    rst_n = 1'b0; wr_en_n = 1; wr_ld_n = 1; rd_en_a_n = 1; rd_en_b_n = 1; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", int'(empty), 1);
    chk("R1 almost_empty", int'(almost_empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 almost_full", int'(almost_full), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R1/R8 default offsets read back: empty offset then full offset
    readback(7, "R1 default empty offset");
    readback(7, "R1 default full offset");

    // R7 load offsets: empty offset 3, full offset 5
    load(9'd3);
    load(9'd5);
    readback(3, "R8 empty offset readback");
    readback(5, "R8 full offset readback");
    readback(3, "R8 readback wraps");
    idle(3);
    chk("R7 load leaves FIFO empty", int'(empty), 1);
    chk("R8 readback leaves FIFO empty", int'(almost_empty), 1);

    // R9 empty latency after first write
    push(9'd10);
    chk("R9 empty after write edge", int'(empty), 1);
    idle(1);
    chk("R9 empty after one rclk edge", int'(empty), 1);
    idle(1);
    chk("R9 empty after two rclk edges", int'(empty), 0);

    // R5 almost_empty threshold (offset 3)
    push(9'd11); push(9'd12);
    idle(3);
    chk("R5 ae at 3 words", int'(almost_empty), 1);
    push(9'd13);
    idle(3);
    chk("R5 ae at 4 words", int'(almost_empty), 0);

    // R10 simultaneous read and write keep count at 4
    for (int i = 0; i < 5; i++) begin
      both(9'(20 + i));
      chk("R10 not full and empty", int'(full && empty), 0);
    end
    idle(3);
    chk("R10 count unchanged (ae)", int'(almost_empty), 0);
    chk("R10 count unchanged (empty)", int'(empty), 0);

    // R3 drain and empty read
    repeat (4) pop();
    idle(1);
    chk("R3 empty after drain", int'(empty), 1);
    last = rd_data;
    pop();
    chk("R3 read while empty holds rd_data", int'(rd_data), int'(last));
    chk("R3 empty stays", int'(empty), 1);
    idle(3);

    // R4/R6 fill to full
    for (int i = 0; i < 512; i++) begin
      push(9'((i * 37 + 5) % 512));
      if (i == 505) chk("R6 af with 6 free", int'(almost_full), 0);
      if (i == 506) chk("R6 af with 5 free", int'(almost_full), 1);
      if (i == 510) chk("R4 not full at 511", int'(full), 0);
    end
    chk("R4 full at 512", int'(full), 1);
    push(9'h1FF);
    chk("R2 write into full dropped", int'(full), 1);
    idle(3);

    for (int i = 0; i < 512; i++) pop();
    idle(1);
    chk("R4 empty after 512 reads", int'(empty), 1);
    chk("R2 dropped word never read", exp_q.size(), 0);
    pop();
    idle(3);
    chk("R6 af cleared after drain", int'(almost_full), 0);
    chk("R4 full cleared after drain", int'(full), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule